// File: doc/BRIEF.md
# Blocking Bus Line-Fill Sequencer

This block runs one cache-line read at a time over a synchronous processor-memory bus that is held for the whole transfer. A requester presents a line address with a valid/ready handshake. Once accepted, the sequencer takes the bus and walks it through four phases. One cycle is spent on arbitration and one on issuing the read command. A fixed number of cycles then covers the memory controller's access latency. Finally the line comes back as a burst of full-width beats in consecutive cycles, in ascending address order.

The bus stays owned from the arbitration cycle through the final beat. No new request is taken while a transfer runs. A pending request stays waiting on its valid line and is taken in the last beat cycle, so its arbitration starts in the very next cycle. After the last beat the block pulses a done flag. It also reports how many cycles the completed fill took, so a bench can read both the fill latency and the back-to-back line period. With the default parameters (64-bit bus, 64-byte line, six wait cycles) a fill takes 1 + 1 + 6 + 8 = 16 cycles.

Top module: `line_fill_seq`

## Requirements
- R1: After reset the block is idle: busy_o, arb_o, cmd_valid_o, beat_valid_o and line_done_o are low, req_ready_o is high, fill_cycles_o is 0 and beat_data_o is 0.
- R2: req_ready_o is high only when idle or in the final beat cycle. A request is accepted on a clock edge where req_valid_i and req_ready_o are both high, and no other edge accepts one.
- R3: arb_o is high for exactly one cycle, the cycle right after acceptance.
- R4: cmd_valid_o is high for exactly the one cycle after arbitration. cmd_addr_o then carries the accepted address with its low 6 bits (the byte offset within the 64-byte line) forced to zero.
- R5: After the command cycle come exactly 6 wait cycles. In these cycles busy_o is high and neither a command nor a beat is shown.
- R6: After the wait, beat_valid_o is high for 8 consecutive cycles. beat_idx_o counts 0 to 7, and beat_addr_o equals the line base plus 8 times beat_idx_o.
- R7: beat_data_o equals mem_data_i while beat_valid_o is high, and is zero otherwise.
- R8: busy_o stays high without a gap from the arbitration cycle through the final beat. No request is accepted in those cycles except in the final beat.
- R9: line_done_o pulses high for one cycle, in the cycle right after the final beat.
- R10: fill_cycles_o becomes 16 in the same cycle as line_done_o and keeps that value until the next fill completes.
- R11: A request raised during a transfer is held off. Its arbitration cycle is the cycle right after the previous final beat, so a held request gives a 16-cycle line period.
- R12: Asserting rst_ni during a transfer ends it at once. No beat and no line_done_o follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Line read request pending |
| req_addr_i | input | ADDR_W (32) | Byte address inside the requested line |
| req_ready_o | output | 1 | Request accepted on this edge if valid |
| busy_o | output | 1 | Bus held by a transfer |
| arb_o | output | 1 | Arbitration cycle |
| cmd_valid_o | output | 1 | Read command cycle |
| cmd_addr_o | output | ADDR_W (32) | Line-aligned command address |
| mem_data_i | input | DATA_W (64) | Data returned by memory during a beat |
| beat_valid_o | output | 1 | Data beat cycle |
| beat_idx_o | output | IDX_W (3) | Beat number within the line |
| beat_addr_o | output | ADDR_W (32) | Byte address of the current beat |
| beat_data_o | output | DATA_W (64) | Beat data, zero outside beats |
| line_done_o | output | 1 | One-cycle pulse after the final beat |
| fill_cycles_o | output | CNT_W (5) | Cycles taken by the last completed fill |

## Verification
Every phase shows up on a port, so a phase counter that slips or a wrong phase shows one cycle later. The symptoms are arb_o or cmd_valid_o lasting more or fewer than one cycle, the first beat arriving early or late, or a beat index that skips. A wrong latency count shows on fill_cycles_o as soon as line_done_o pulses. A wrong release of the bus shows as req_ready_o rising mid-transfer, or as a held request whose arbitration is not exactly one cycle after the final beat.

// File: rtl/line_fill_pkg.sv
package line_fill_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ARB,
    PH_CMD,
    PH_WAIT,
    PH_DATA
  } phase_e;
endpackage

// File: rtl/lfs_phase_fsm.sv
module lfs_phase_fsm
  import line_fill_pkg::*;
#(
  parameter int ARB_CYC = 1,
  parameter int CMD_CYC = 1,
  parameter int MEM_LAT = 6,
  parameter int BEATS   = 8,
  parameter int CNT_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output phase_e           phase_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, len;

  always_comb begin
    case (phase_q)
      PH_ARB:  len = CNT_W'(ARB_CYC);
      PH_CMD:  len = CNT_W'(CMD_CYC);
      PH_WAIT: len = CNT_W'(MEM_LAT);
      PH_DATA: len = CNT_W'(BEATS);
      default: len = '0;
    endcase
  end

  assign last_o = (phase_q != PH_IDLE) && (cnt_q == len - 1'b1);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (start_i) begin
      phase_d = PH_ARB;
      cnt_d   = '0;
    end else if (phase_q != PH_IDLE) begin
      if (last_o) begin
        cnt_d = '0;
        case (phase_q)
          PH_ARB:  phase_d = PH_CMD;
          PH_CMD:  phase_d = PH_WAIT;
          PH_WAIT: phase_d = PH_DATA;
          default: phase_d = PH_IDLE;
        endcase
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/lfs_beat_gen.sv
module lfs_beat_gen #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int IDX_W  = 3,
  parameter int BB_W   = 3,
  parameter int CNT_W  = 5
) (
  input  logic              in_data_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ADDR_W-1:0] line_base_i,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              beat_valid_o,
  output logic [IDX_W-1:0]  beat_idx_o,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic [DATA_W-1:0] beat_data_o
);
  localparam int OFF_W = IDX_W + BB_W;

  assign beat_valid_o = in_data_i;
  assign beat_idx_o   = in_data_i ? cnt_i[IDX_W-1:0] : '0;

  generate
    if (BB_W > 0) begin : g_wide_beat
      assign beat_addr_o = {line_base_i[ADDR_W-1:OFF_W], beat_idx_o, {BB_W{1'b0}}};
    end else begin : g_byte_beat
      assign beat_addr_o = {line_base_i[ADDR_W-1:OFF_W], beat_idx_o};
    end
  endgenerate

  assign beat_data_o = in_data_i ? mem_data_i : '0;
endmodule

// File: rtl/lfs_fill_meter.sv
module lfs_fill_meter #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             busy_i,
  input  logic             last_beat_i,
  output logic             done_o,
  output logic [CNT_W-1:0] fill_cycles_o
);
  logic [CNT_W-1:0] run_q, fill_q;
  logic             done_q;

  // run_q holds the 1-based cycle number of the current bus cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      fill_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (start_i)     run_q <= CNT_W'(1);
      else if (busy_i) run_q <= run_q + 1'b1;
      if (last_beat_i) fill_q <= run_q;
      done_q <= last_beat_i;
    end
  end

  assign done_o        = done_q;
  assign fill_cycles_o = fill_q;
endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq
  import line_fill_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int LINE_BYTES = 64,
  parameter int ARB_CYC    = 1,
  parameter int CMD_CYC    = 1,
  parameter int MEM_LAT    = 6,
  localparam int BEAT_BYTES = DATA_W / 8,
  localparam int BEATS      = LINE_BYTES / BEAT_BYTES,
  localparam int IDX_W      = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int BB_W       = $clog2(BEAT_BYTES),
  localparam int OFF_W      = IDX_W + BB_W,
  localparam int CNT_W      = $clog2(ARB_CYC + CMD_CYC + MEM_LAT + BEATS) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              busy_o,
  output logic              arb_o,
  output logic              cmd_valid_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic              beat_valid_o,
  output logic [IDX_W-1:0]  beat_idx_o,
  output logic [ADDR_W-1:0] beat_addr_o,
  output logic [DATA_W-1:0] beat_data_o,
  output logic              line_done_o,
  output logic [CNT_W-1:0]  fill_cycles_o
);
  phase_e            phase;
  logic [CNT_W-1:0]  cnt;
  logic              last, start, last_beat, in_data;
  logic [ADDR_W-1:0] base_q;

  assign in_data     = (phase == PH_DATA);
  assign last_beat   = in_data && last;
  // bus released only once the final beat is on the wires
  assign req_ready_o = (phase == PH_IDLE) || last_beat;
  assign start       = req_valid_i && req_ready_o;

  lfs_phase_fsm #(
    .ARB_CYC(ARB_CYC), .CMD_CYC(CMD_CYC), .MEM_LAT(MEM_LAT),
    .BEATS(BEATS), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .phase_o(phase), .cnt_o(cnt), .last_o(last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    base_q <= '0;
    else if (start) base_q <= {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  end

  lfs_beat_gen #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .BB_W(BB_W), .CNT_W(CNT_W)
  ) u_beat (
    .in_data_i(in_data), .cnt_i(cnt), .line_base_i(base_q), .mem_data_i(mem_data_i),
    .beat_valid_o(beat_valid_o), .beat_idx_o(beat_idx_o),
    .beat_addr_o(beat_addr_o), .beat_data_o(beat_data_o)
  );

  lfs_fill_meter #(.CNT_W(CNT_W)) u_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start),
    .busy_i(phase != PH_IDLE), .last_beat_i(last_beat),
    .done_o(line_done_o), .fill_cycles_o(fill_cycles_o)
  );

  assign busy_o      = (phase != PH_IDLE);
  assign arb_o       = (phase == PH_ARB);
  assign cmd_valid_o = (phase == PH_CMD);
  assign cmd_addr_o  = base_q;
endmodule

// File: rtl/line_fill_seq_chk.sv
module line_fill_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int IDX_W  = 3,
  parameter int BEATS  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              busy_o,
  input logic              arb_o,
  input logic              cmd_valid_o,
  input logic [ADDR_W-1:0] cmd_addr_o,
  input logic              beat_valid_o,
  input logic [IDX_W-1:0]  beat_idx_o,
  input logic              line_done_o
);
  logic final_beat;
  assign final_beat = beat_valid_o && (beat_idx_o == IDX_W'(BEATS - 1));

  // R2
  accept_to_arb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (arb_o && busy_o));

  // R3
  arb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_o |=> (!arb_o && cmd_valid_o));

  // R4
  cmd_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_addr_o[OFF_W-1:0] == '0));

  // R5
  cmd_then_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> (busy_o && !cmd_valid_o && !beat_valid_o));

  // R6
  beat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_valid_o && !final_beat) |=>
      (beat_valid_o && beat_idx_o == $past(beat_idx_o) + 1'b1));

  // R8
  busy_blocks_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !final_beat) |-> !req_ready_o);

  // R9
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    final_beat |=> line_done_o);

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |=> !line_done_o);
endmodule

bind line_fill_seq line_fill_seq_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .BEATS(BEATS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .busy_o(busy_o), .arb_o(arb_o), .cmd_valid_o(cmd_valid_o), .cmd_addr_o(cmd_addr_o),
  .beat_valid_o(beat_valid_o), .beat_idx_o(beat_idx_o), .line_done_o(line_done_o)
);

// File: tb/line_fill_seq_bench.sv
`timescale 1ns/1ps
module line_fill_seq_bench;
  localparam int FILL = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [63:0] mem_data_i = '0;
  logic        req_ready_o, busy_o, arb_o, cmd_valid_o;
  logic [31:0] cmd_addr_o, beat_addr_o;
  logic        beat_valid_o, line_done_o;
  logic [2:0]  beat_idx_o;
  logic [63:0] beat_data_o;
  logic [4:0]  fill_cycles_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  line_fill_seq u_line_fill_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .req_ready_o(req_ready_o), .busy_o(busy_o), .arb_o(arb_o), .cmd_valid_o(cmd_valid_o),
    .cmd_addr_o(cmd_addr_o), .mem_data_i(mem_data_i), .beat_valid_o(beat_valid_o),
    .beat_idx_o(beat_idx_o), .beat_addr_o(beat_addr_o), .beat_data_o(beat_data_o),
    .line_done_o(line_done_o), .fill_cycles_o(fill_cycles_o)
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  function automatic logic [63:0] pat(input logic [31:0] a);
    return {~a, a};
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    req_valid_i = 1'b0;
    step(); step();
    rst_ni = 1'b1;
    step();
  endtask

  task automatic t_reset_state();
    chk(!busy_o && !arb_o && !cmd_valid_o, "R1 idle flags", {busy_o, arb_o, cmd_valid_o}, 0);
    chk(!beat_valid_o && !line_done_o, "R1 no beat/done", {beat_valid_o, line_done_o}, 0);
    chk(req_ready_o, "R1 ready", req_ready_o, 1);
    chk(fill_cycles_o == 0, "R1 fill count", fill_cycles_o, 0);
    chk(beat_data_o == 0, "R1 beat data", beat_data_o, 0);
  endtask

  // single read with an unaligned address, full phase walk
  task automatic t_single(input logic [31:0] addr);
    logic [31:0] base;
    bit ok;
    base = {addr[31:6], 6'b0};
    req_valid_i = 1'b1;
    req_addr_i  = addr;
    #1;
    chk(req_ready_o, "R2 ready when idle", req_ready_o, 1);
    step();
    chk(arb_o && busy_o, "R3 arbitration cycle", {arb_o, busy_o}, 3);
    chk(!req_ready_o, "R2 not ready in arb", req_ready_o, 0);
    req_valid_i = 1'b0;
    step();
    chk(cmd_valid_o && !arb_o, "R4 command cycle", {cmd_valid_o, arb_o}, 2);
    chk(cmd_addr_o == base, "R4 aligned address", cmd_addr_o, base);
    ok = 1'b1;
    for (int w = 0; w < 6; w++) begin
      step();
      if (cmd_valid_o || beat_valid_o || !busy_o || req_ready_o) ok = 1'b0;
    end
    chk(ok, "R5 six wait cycles", ok, 1);
    for (int i = 0; i < 8; i++) begin
      step();
      mem_data_i = pat(base + 32'(i * 8));
      #1;
      chk(beat_valid_o && beat_idx_o == 3'(i), "R6 beat index", beat_idx_o, i);
      chk(beat_addr_o == base + 32'(i * 8), "R6 beat address", beat_addr_o, base + 32'(i * 8));
      chk(beat_data_o == pat(base + 32'(i * 8)), "R7 beat data", beat_data_o,
          pat(base + 32'(i * 8)));
      chk(busy_o && (req_ready_o == (i == 7)), "R8 busy and ready", {busy_o, req_ready_o},
          {1'b1, i == 7});
      chk(!line_done_o, "R9 no early done", line_done_o, 0);
    end
    step();
    chk(line_done_o, "R9 done after last beat", line_done_o, 1);
    chk(fill_cycles_o == 5'(FILL), "R10 fill latency", fill_cycles_o, FILL);
    chk(!busy_o && !beat_valid_o, "R8 bus released", {busy_o, beat_valid_o}, 0);
    chk(beat_data_o == 0, "R7 data zero outside beat", beat_data_o, 0);
    step();
    chk(!line_done_o, "R9 single-cycle done", line_done_o, 1'b0);
    chk(fill_cycles_o == 5'(FILL), "R10 fill holds", fill_cycles_o, FILL);
    mem_data_i = '0;
  endtask

  // request held across two lines: next arbitration in the cycle after the final beat
  task automatic t_back_to_back(input logic [31:0] a, input logic [31:0] b);
    int arb_at[2];
    int done_at[2];
    int n_arb = 0;
    int n_done = 0;
    logic [31:0] cmd_b = '0;
    req_valid_i = 1'b1;
    req_addr_i  = a;
    for (int k = 1; k <= 34; k++) begin
      step();
      if (arb_o) begin
        if (n_arb < 2) arb_at[n_arb] = k;
        n_arb++;
      end
      if (line_done_o) begin
        if (n_done < 2) done_at[n_done] = k;
        n_done++;
      end
      if (cmd_valid_o && k > 17) cmd_b = cmd_addr_o;
      if (k == 1) req_addr_i = b;
      if (k == 17) req_valid_i = 1'b0;
    end
    chk(n_arb == 2 && arb_at[0] == 1 && arb_at[1] == 17, "R11 back-to-back arb",
        arb_at[1], 17);
    chk(n_done == 2 && done_at[0] == 17 && done_at[1] == 33, "R11 line period 16",
        done_at[1] - done_at[0], FILL);
    chk(cmd_b == {b[31:6], 6'b0}, "R4 second command address", cmd_b, {b[31:6], 6'b0});
    chk(fill_cycles_o == 5'(FILL), "R10 second fill latency", fill_cycles_o, FILL);
  endtask

  // request raised mid-transfer is held until the bus is released
  task automatic t_held(input logic [31:0] a, input logic [31:0] c);
    int arb2 = 0;
    bit early = 1'b0;
    logic [31:0] cmd_c = '0;
    req_valid_i = 1'b1;
    req_addr_i  = a;
    step();
    req_valid_i = 1'b0;
    for (int k = 2; k <= 20; k++) begin
      step();
      if (k == 5) begin
        req_valid_i = 1'b1;
        req_addr_i  = c;
        #1;
        chk(!req_ready_o, "R8 held off while busy", req_ready_o, 0);
      end
      if (arb_o && k < 17) early = 1'b1;
      if (arb_o && k >= 17 && arb2 == 0) begin
        arb2 = k;
        req_valid_i = 1'b0;
      end
      if (cmd_valid_o && k > 17) cmd_c = cmd_addr_o;
    end
    chk(!early && arb2 == 17, "R11 held request arb cycle", arb2, 17);
    chk(cmd_c == {c[31:6], 6'b0}, "R11 held request address", cmd_c, {c[31:6], 6'b0});
    for (int k = 21; k <= 34; k++) step();
  endtask

  task automatic t_reset_mid(input logic [31:0] a);
    bit seen = 1'b0;
    req_valid_i = 1'b1;
    req_addr_i  = a;
    step();
    req_valid_i = 1'b0;
    for (int k = 0; k < 11; k++) step();
    chk(beat_valid_o, "R12 in data phase", beat_valid_o, 1);
    rst_ni = 1'b0;
    #1;
    chk(!busy_o && !beat_valid_o && req_ready_o, "R12 aborted at once",
        {busy_o, beat_valid_o, req_ready_o}, 1);
    step();
    rst_ni = 1'b1;
    for (int k = 0; k < 20; k++) begin
      step();
      if (line_done_o || beat_valid_o || busy_o) seen = 1'b1;
    end
    chk(!seen, "R12 no done after abort", seen, 0);
    chk(fill_cycles_o == 0, "R1 fill cleared by reset", fill_cycles_o, 0);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_single(32'h0000_1234);
    t_single(32'hFFFF_FFFF);
    t_back_to_back(32'h0000_0040, 32'h8000_00FF);
    t_held(32'h0000_2000, 32'h0000_3FC7);
    t_reset_mid(32'h0000_0100);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule